// File: doc/BRIEF.md
# Serial Flash Bulk DMA Engine

This block moves the data phase of a serial NAND flash operation between the flash lines and system memory, so the CPU does not copy each byte. Before a bulk phase, software uses the separate programmed-I/O path to send the command, address and dummy cycles while chip select stays asserted. Software then writes a 32-bit memory byte address, a byte count with an encoded line width, and a trigger that picks the direction. The engine then runs by itself and raises a maskable interrupt when it finishes.

On the memory side the engine is a 32-bit word master with a request/grant handshake and per-byte enables. Bytes use big-endian order within a word, and unaligned starts and trailing partial words write only their own bytes. On the flash side it exchanges single bytes with the existing serial shifter through a request/acknowledge pair, and it tells the shifter the direction and the line width. Each trigger has its own length limit for each direction: up to 2080 bytes from flash to memory and up to 520 bytes from memory to flash. A longer count is cut to the limit. The engine never drives chip select.

Top module: `snand_bulk_dma`

## Requirements
- R1: After reset, status bit 3 (offset 0x40), pending bit 0 (offset 0x20), enable bit 20 (offset 0x00) and `irq` are all 0. The address register at 0x1C reads back all 32 bits. The length register at 0x24 reads back the count in bits 11:0 and the width code in bits 29:28. A read returns the register that `reg_addr` selected at the previous clock edge.
- R2: A trigger write to 0x18 with bit 0 = 0 moves bytes from flash to memory. Byte k of the stream lands at byte address start+k. A byte whose address has low bits L goes on `mem_wdata[31-8L -: 8]` with `mem_be[3-L]` set. Enables are set only for bytes of the transfer. `mem_addr` is word aligned.
- R3: A trigger write with bit 0 = 1 moves bytes from memory to flash. The engine reads words (`mem_we`=0, data taken in the grant cycle) and presents the bytes from start address upward on `sh_txbyte`, using the lane mapping of R2.
- R4: The count used by a trigger is the written count, limited to 2080 for flash-to-memory and 520 for memory-to-flash.
- R5: A count of 0 completes with no memory or shifter request and sets pending.
- R6: Status bit 3 reads 1 from the edge after the trigger write until the transfer completes. Pending rises on the same edge where the engine becomes idle. `mem_req` and `sh_req` are never high together, and neither is high while the engine is idle.
- R7: Writing 1 to bit 0 at 0x20 clears pending. Writing 0 leaves it unchanged.
- R8: `irq` is a registered copy of (enable bit 20 AND pending). It changes one edge after either input changes.
- R9: A trigger write while a transfer is running or being started is ignored.
- R10: During a transfer, `sh_dir` equals trigger bit 0 and `sh_width` equals length bits 29:28 captured at the trigger.
- R11: While `mem_req` is high without `mem_gnt`, the request stays high and `mem_addr`, `mem_we`, `mem_wdata` and `mem_be` hold their values.
- R12: While `sh_req` is high without `sh_ack`, the request stays high and `sh_txbyte` holds. Each acknowledged cycle moves exactly one byte, and `sh_rxbyte` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory grant, completes the access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, big-endian lanes |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_rdata | input | 32 | Read data, valid in grant cycle |
| sh_req | output | 1 | Byte request to the shifter |
| sh_ack | input | 1 | Shifter moved one byte |
| sh_dir | output | 1 | 0 = flash to memory, 1 = memory to flash |
| sh_width | output | 2 | Line width code |
| sh_txbyte | output | 8 | Byte to send |
| sh_rxbyte | input | 8 | Received byte, valid with ack |

## Verification
The bench starts transfers at an unaligned address with a count that ends mid-word. A design with a wrong lane or enable mapping would overwrite the guard bytes around the buffer or put the bytes in the wrong order. Counts above both direction limits are used. An engine that does not clamp the count would write past byte 2080 or send more than 520 bytes, and one that clamps with the wrong limit would stop short. Grants and acks are stalled in a fixed pattern, so a design that drops or repeats a byte across a stall would corrupt the data. Further tests cover a zero count, a second trigger during a running transfer, a zero write to pending, and the interrupt enable gating. These catch a design that hangs, starts a second transfer, clears pending wrongly, or ignores the enable.

// File: rtl/snand_dma_pkg.sv
package snand_dma_pkg;
  localparam int RA_W = 8;
  localparam logic [RA_W-1:0] OFS_CFG   = 8'h00;
  localparam logic [RA_W-1:0] OFS_TRIG  = 8'h18;
  localparam logic [RA_W-1:0] OFS_MADDR = 8'h1C;
  localparam logic [RA_W-1:0] OFS_PEND  = 8'h20;
  localparam logic [RA_W-1:0] OFS_LEN   = 8'h24;
  localparam logic [RA_W-1:0] OFS_STAT  = 8'h40;
  localparam int IE_BIT   = 20;
  localparam int BUSY_BIT = 3;
  localparam int WID_LSB  = 28;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SHIFT, ST_MWR, ST_MRD, ST_DONE
  } dma_state_e;

  typedef enum logic {
    DIR_TO_MEM   = 1'b0,
    DIR_TO_FLASH = 1'b1
  } dma_dir_e;
endpackage

// File: rtl/snand_dma_regs.sv
module snand_dma_regs
  import snand_dma_pkg::*;
#(
  parameter int AW           = 32,
  parameter int LEN_W        = 12,
  parameter int MAX_TO_MEM   = 2080,
  parameter int MAX_TO_FLASH = 520
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic             done,
  output logic             start,
  output logic             start_dir,
  output logic [AW-1:0]    start_addr,
  output logic [LEN_W-1:0] start_len,
  output logic [1:0]       start_width,
  output logic             irq
);
  localparam logic [LEN_W-1:0] LIM_MEM   = LEN_W'(MAX_TO_MEM);
  localparam logic [LEN_W-1:0] LIM_FLASH = LEN_W'(MAX_TO_FLASH);

  logic             ie_q, pend_q, irq_q, start_q, dir_q;
  logic [AW-1:0]    maddr_q, saddr_q;
  logic [LEN_W-1:0] len_q, slen_q;
  logic [1:0]       wid_q, swid_q;
  logic [31:0]      rd_q, rd_d;

  logic wr_cfg, wr_trig, wr_maddr, wr_pend, wr_len, eng_busy, accept;
  logic [LEN_W-1:0] lim, clamped;

  assign wr_cfg   = reg_we && (reg_addr == OFS_CFG);
  assign wr_trig  = reg_we && (reg_addr == OFS_TRIG);
  assign wr_maddr = reg_we && (reg_addr == OFS_MADDR);
  assign wr_pend  = reg_we && (reg_addr == OFS_PEND);
  assign wr_len   = reg_we && (reg_addr == OFS_LEN);
  assign eng_busy = busy | start_q;
  assign accept   = wr_trig && !eng_busy;
  assign lim      = reg_wdata[0] ? LIM_FLASH : LIM_MEM;
  assign clamped  = (len_q > lim) ? lim : len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      maddr_q <= '0;
      saddr_q <= '0;
      len_q   <= '0;
      slen_q  <= '0;
      wid_q   <= '0;
      swid_q  <= '0;
    end else begin
      if (wr_cfg)   ie_q    <= reg_wdata[IE_BIT];
      if (wr_maddr) maddr_q <= reg_wdata[AW-1:0];
      if (wr_len) begin
        len_q <= reg_wdata[LEN_W-1:0];
        wid_q <= reg_wdata[WID_LSB +: 2];
      end
      if (done)                         pend_q <= 1'b1;
      else if (wr_pend && reg_wdata[0]) pend_q <= 1'b0;
      irq_q   <= ie_q & pend_q;
      start_q <= accept;
      if (accept) begin
        dir_q   <= reg_wdata[0];
        saddr_q <= maddr_q;
        slen_q  <= clamped;
        swid_q  <= wid_q;
      end
    end
  end

  always_comb begin
    rd_d = '0;
    case (reg_addr)
      OFS_CFG:   rd_d[IE_BIT] = ie_q;
      OFS_MADDR: rd_d[AW-1:0] = maddr_q;
      OFS_PEND:  rd_d[0] = pend_q;
      OFS_LEN: begin
        rd_d[LEN_W-1:0]     = len_q;
        rd_d[WID_LSB +: 2]  = wid_q;
      end
      OFS_STAT:  rd_d[BUSY_BIT] = eng_busy;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign reg_rdata   = rd_q;
  assign start       = start_q;
  assign start_dir   = dir_q;
  assign start_addr  = saddr_q;
  assign start_len   = slen_q;
  assign start_width = swid_q;
  assign irq         = irq_q;

  // R9: a trigger seen while the engine runs never produces a start
  a_r9_trig_while_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_trig && busy) |=> !start_q);
  // R9: starts are single pulses, never back to back
  a_r9_single_start: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  // R7: a one written to pending clears it unless completion collides
  a_r7_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && reg_wdata[0] && !done) |=> !pend_q);
  // R4: the captured count never exceeds the larger limit
  a_r4_len_cap: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (slen_q <= ((MAX_TO_MEM > MAX_TO_FLASH) ? LIM_MEM : LIM_FLASH)));
endmodule

// File: rtl/snand_dma_lanes.sv
module snand_dma_lanes #(
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             put,
  input  logic [LB-1:0]    put_lane,
  input  logic [7:0]       put_byte,
  input  logic             load,
  input  logic [DW-1:0]    load_word,
  input  logic             clr,
  input  logic [LB-1:0]    sel_lane,
  output logic [DW-1:0]    word,
  output logic [LANES-1:0] be,
  output logic [7:0]       sel_byte
);
  wire [DW-1:0]    word_w;
  wire [LANES-1:0] be_w;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = DW - 1 - 8 * g;
    logic [7:0] b_q;
    logic       e_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        b_q <= '0;
        e_q <= 1'b0;
      end else if (load) begin
        b_q <= load_word[HI -: 8];
        e_q <= 1'b0;
      end else if (put && (put_lane == LB'(g))) begin
        b_q <= put_byte;
        e_q <= 1'b1;
      end else if (clr) begin
        e_q <= 1'b0;
      end
    end
    assign word_w[HI -: 8]       = b_q;
    assign be_w[LANES - 1 - g]   = e_q;
  end

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < LANES; i++) begin
      if (sel_lane == LB'(i)) sel_byte = word_w[DW - 1 - 8 * i -: 8];
    end
  end

  assign word = word_w;
  assign be   = be_w;
endmodule

// File: rtl/snand_dma_ctrl.sv
module snand_dma_ctrl
  import snand_dma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int LEN_W   = 12,
  parameter int LEN_CAP = 2080,
  localparam int LANES = DW / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_dir,
  input  logic [AW-1:0]    start_addr,
  input  logic [LEN_W-1:0] start_len,
  input  logic [1:0]       start_width,
  output logic             busy,
  output logic             done,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [LANES-1:0] mem_be,
  input  logic [DW-1:0]    mem_rdata,
  output logic             sh_req,
  input  logic             sh_ack,
  output logic             sh_dir,
  output logic [1:0]       sh_width,
  output logic [7:0]       sh_txbyte,
  input  logic [7:0]       sh_rxbyte
);
  dma_state_e       st_q;
  dma_dir_e         dir_q;
  logic [LB-1:0]    lane_q;
  logic [AW-1:0]    waddr_q;
  logic [LEN_W-1:0] rem_q;
  logic [1:0]       wid_q;

  logic last_lane, last_byte, hs_sh, hs_wr, hs_rd;
  logic [DW-1:0]    buf_word;
  logic [LANES-1:0] buf_be;
  logic [7:0]       buf_sel;

  assign last_lane = (lane_q == LB'(LANES - 1));
  assign last_byte = (rem_q == LEN_W'(1));
  assign hs_sh     = (st_q == ST_SHIFT) && sh_ack;
  assign hs_wr     = (st_q == ST_MWR) && mem_gnt;
  assign hs_rd     = (st_q == ST_MRD) && mem_gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      dir_q   <= DIR_TO_MEM;
      lane_q  <= '0;
      waddr_q <= '0;
      rem_q   <= '0;
      wid_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          dir_q   <= dma_dir_e'(start_dir);
          lane_q  <= start_addr[LB-1:0];
          waddr_q <= {start_addr[AW-1:LB], {LB{1'b0}}};
          rem_q   <= start_len;
          wid_q   <= start_width;
          if (start_len == '0)  st_q <= ST_DONE;
          else if (start_dir)   st_q <= ST_MRD;
          else                  st_q <= ST_SHIFT;
        end
        ST_SHIFT: if (sh_ack) begin
          lane_q <= lane_q + LB'(1);
          rem_q  <= rem_q - LEN_W'(1);
          if (dir_q == DIR_TO_MEM) begin
            if (last_lane || last_byte) st_q <= ST_MWR;
          end else if (last_byte) begin
            st_q <= ST_DONE;
          end else if (last_lane) begin
            waddr_q <= waddr_q + AW'(LANES);
            st_q    <= ST_MRD;
          end
        end
        ST_MWR: if (mem_gnt) begin
          waddr_q <= waddr_q + AW'(LANES);
          st_q    <= (rem_q == '0) ? ST_DONE : ST_SHIFT;
        end
        ST_MRD: if (mem_gnt) st_q <= ST_SHIFT;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  snand_dma_lanes #(.DW(DW)) u_lanes (
    .clk       (clk),
    .rst       (rst),
    .put       (hs_sh && (dir_q == DIR_TO_MEM)),
    .put_lane  (lane_q),
    .put_byte  (sh_rxbyte),
    .load      (hs_rd),
    .load_word (mem_rdata),
    .clr       (hs_wr),
    .sel_lane  (lane_q),
    .word      (buf_word),
    .be        (buf_be),
    .sel_byte  (buf_sel)
  );

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign mem_req   = (st_q == ST_MWR) || (st_q == ST_MRD);
  assign mem_we    = (st_q == ST_MWR);
  assign mem_addr  = waddr_q;
  assign mem_wdata = buf_word;
  assign mem_be    = (st_q == ST_MWR) ? buf_be : {LANES{1'b1}};
  assign sh_req    = (st_q == ST_SHIFT);
  assign sh_dir    = dir_q;
  assign sh_width  = wid_q;
  assign sh_txbyte = buf_sel;

  // R11: a stalled memory request holds every qualifier
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_be)));
  // R12: a stalled shifter request holds its byte
  a_r12_sh_hold: assert property (@(posedge clk) disable iff (rst)
    (sh_req && !sh_ack) |=> (sh_req && $stable(sh_txbyte)));
  // R6: the two sides never request together, and only while busy
  a_r6_one_side: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && sh_req));
  a_r6_req_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_req || sh_req) |-> busy);
  // R2: a memory write always carries at least one enabled byte
  a_r2_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be != '0));
  // R4: the remaining count stays within the largest limit
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (rst)
    rem_q <= LEN_W'(LEN_CAP));
  // R2: memory addresses stay word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[LB-1:0] == '0));
endmodule

// File: rtl/snand_bulk_dma.sv
module snand_bulk_dma
  import snand_dma_pkg::*;
#(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int LEN_W        = 12,
  parameter int MAX_TO_MEM   = 2080,
  parameter int MAX_TO_FLASH = 520,
  localparam int LANES   = DW / 8,
  localparam int LEN_CAP = (MAX_TO_MEM > MAX_TO_FLASH) ? MAX_TO_MEM : MAX_TO_FLASH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [LANES-1:0] mem_be,
  input  logic [DW-1:0]    mem_rdata,
  output logic             sh_req,
  input  logic             sh_ack,
  output logic             sh_dir,
  output logic [1:0]       sh_width,
  output logic [7:0]       sh_txbyte,
  input  logic [7:0]       sh_rxbyte
);
  logic             busy, done, start, start_dir;
  logic [AW-1:0]    start_addr;
  logic [LEN_W-1:0] start_len;
  logic [1:0]       start_width;

  snand_dma_regs #(
    .AW(AW), .LEN_W(LEN_W), .MAX_TO_MEM(MAX_TO_MEM), .MAX_TO_FLASH(MAX_TO_FLASH)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .busy        (busy),
    .done        (done),
    .start       (start),
    .start_dir   (start_dir),
    .start_addr  (start_addr),
    .start_len   (start_len),
    .start_width (start_width),
    .irq         (irq)
  );

  snand_dma_ctrl #(
    .AW(AW), .DW(DW), .LEN_W(LEN_W), .LEN_CAP(LEN_CAP)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_dir   (start_dir),
    .start_addr  (start_addr),
    .start_len   (start_len),
    .start_width (start_width),
    .busy        (busy),
    .done        (done),
    .mem_req     (mem_req),
    .mem_gnt     (mem_gnt),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_be      (mem_be),
    .mem_rdata   (mem_rdata),
    .sh_req      (sh_req),
    .sh_ack      (sh_ack),
    .sh_dir      (sh_dir),
    .sh_width    (sh_width),
    .sh_txbyte   (sh_txbyte),
    .sh_rxbyte   (sh_rxbyte)
  );
endmodule

// File: tb/tb_snand_bulk_dma.sv
`timescale 1ns/1ps
module tb_snand_bulk_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_req, mem_we, sh_req, sh_dir;
  logic        mem_gnt = 1'b0, sh_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [1:0]  sh_width;
  logic [7:0]  sh_txbyte, sh_rxbyte;

  always #2 clk = ~clk;

  snand_bulk_dma dut (.*);

  logic [7:0] mem [0:8191];
  logic [7:0] sink [0:2047];
  int rx_idx = 0, tx_cnt = 0, mwr_cnt = 0, cyc = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  function automatic logic [7:0] fpat(int k);
    return 8'(k * 7 + 3);
  endfunction
  function automatic logic [7:0] gpat(int k);
    return 8'(k * 13 + 5);
  endfunction

  assign sh_rxbyte = fpat(rx_idx);
  assign mem_rdata = {mem[{mem_addr[12:2], 2'd0}], mem[{mem_addr[12:2], 2'd1}],
                      mem[{mem_addr[12:2], 2'd2}], mem[{mem_addr[12:2], 2'd3}]};

  // responders: stalls in a fixed pattern
  always @(negedge clk) begin
    cyc     <= cyc + 1;
    sh_ack  <= sh_req && (cyc % 3 != 2);
    mem_gnt <= mem_req && (cyc % 4 != 0);
  end

  always @(posedge clk) begin
    if (sh_req && sh_ack && !sh_dir) rx_idx <= rx_idx + 1;
    if (sh_req && sh_ack && sh_dir) begin
      sink[tx_cnt % 2048] <= sh_txbyte;
      tx_cnt <= tx_cnt + 1;
    end
    if (mem_req && mem_gnt && mem_we) begin
      mwr_cnt <= mwr_cnt + 1;
      for (int l = 0; l < 4; l++)
        if (mem_be[3-l]) mem[{mem_addr[12:2], 2'(l)}] <= mem_wdata[31-8*l -: 8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      reg_read(8'h40, s);
      if (!s[3]) break;
    end
  endtask

  task automatic start_xfer(input int addr, input int len, input int wid, input int dir);
    reg_write(8'h1C, 32'(addr));
    reg_write(8'h24, (32'(wid) << 28) | 32'(len));
    reg_write(8'h18, 32'(dir));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    reg_read(8'h40, v); chk("R1 status", v, 32'd0);
    reg_read(8'h20, v); chk("R1 pending", v, 32'd0);
    reg_read(8'h00, v); chk("R1 cfg", v, 32'd0);
    reg_write(8'h1C, 32'hA5C3_0F12);
    reg_read(8'h1C, v); chk("R1 addr readback", v, 32'hA5C3_0F12);
    reg_write(8'h24, 32'h2000_0ABC);
    reg_read(8'h24, v); chk("R1 len readback", v, 32'h2000_0ABC);
  endtask

  task automatic t_rx(input int addr, input int len, input string tag);
    int r0 = rx_idx;
    logic [31:0] v;
    start_xfer(addr, len, 2, 0);
    reg_read(8'h40, v); chk({tag, " R6 busy"}, v & 32'h8, 32'h8);
    chk({tag, " R10 width"}, {30'd0, sh_width}, 32'd2);
    chk({tag, " R10 dir"}, {31'd0, sh_dir}, 32'd0);
    wait_idle();
    reg_read(8'h20, v); chk({tag, " R6 pending"}, v, 32'd1);
    chk({tag, " R12 count"}, 32'(rx_idx - r0), 32'(len));
    for (int k = 0; k < len; k++)
      chk({tag, " R2/R11 byte"}, {24'd0, mem[addr + k]}, {24'd0, fpat(r0 + k)});
    chk({tag, " R2 guard low"}, {24'd0, mem[addr - 1]}, 32'hEE);
    chk({tag, " R2 guard high"}, {24'd0, mem[addr + len]}, 32'hEE);
    reg_write(8'h20, 32'd1);
  endtask

  task automatic t_tx();
    int t0 = tx_cnt;
    for (int k = 0; k < 7; k++) mem[16'h402 + k] = gpat(k);
    start_xfer(16'h402, 7, 1, 1);
    repeat (4) @(negedge clk);
    chk("R10 tx dir", {31'd0, sh_dir}, 32'd1);
    chk("R10 tx width", {30'd0, sh_width}, 32'd1);
    wait_idle();
    chk("R3 tx count", 32'(tx_cnt - t0), 32'd7);
    for (int k = 0; k < 7; k++)
      chk("R3/R12 tx byte", {24'd0, sink[(t0 + k) % 2048]}, {24'd0, gpat(k)});
    reg_write(8'h20, 32'd1);
  endtask

  task automatic t_w1c_irq();
    logic [31:0] v;
    int w0 = mwr_cnt, r0 = rx_idx;
    start_xfer(16'h700, 0, 0, 0);
    wait_idle();
    reg_read(8'h20, v); chk("R5 zero pending", v, 32'd1);
    chk("R5 no mem write", 32'(mwr_cnt - w0), 32'd0);
    chk("R5 no shift", 32'(rx_idx - r0), 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 irq masked", {31'd0, irq}, 32'd0);
    reg_write(8'h00, 32'h0010_0000);
    repeat (2) @(negedge clk);
    chk("R8 irq enabled", {31'd0, irq}, 32'd1);
    reg_write(8'h20, 32'd0);
    reg_read(8'h20, v); chk("R7 zero write keeps", v, 32'd1);
    reg_write(8'h20, 32'd1);
    reg_read(8'h20, v); chk("R7 w1c", v, 32'd0);
    repeat (2) @(negedge clk);
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_clamp();
    int r0 = rx_idx, t0;
    start_xfer(16'h800, 3000, 0, 0);
    wait_idle();
    chk("R4 rx clamp count", 32'(rx_idx - r0), 32'd2080);
    chk("R4 rx last", {24'd0, mem[16'h800 + 2079]}, {24'd0, fpat(r0 + 2079)});
    chk("R4 rx past end", {24'd0, mem[16'h800 + 2080]}, 32'hEE);
    for (int k = 0; k < 600; k++) mem[16'h1200 + k] = gpat(k);
    t0 = tx_cnt;
    start_xfer(16'h1200, 600, 0, 1);
    wait_idle();
    chk("R4 tx clamp count", 32'(tx_cnt - t0), 32'd520);
    chk("R4 tx last", {24'd0, sink[(t0 + 519) % 2048]}, {24'd0, gpat(519)});
    reg_write(8'h20, 32'd1);
  endtask

  task automatic t_ignore();
    int r0 = rx_idx, t0 = tx_cnt;
    logic [31:0] v;
    start_xfer(16'h600, 40, 0, 0);
    reg_write(8'h24, 32'd4);
    reg_write(8'h18, 32'd1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R9 rx count", 32'(rx_idx - r0), 32'd40);
    chk("R9 no tx", 32'(tx_cnt - t0), 32'd0);
    reg_read(8'h40, v); chk("R9 idle", v, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'hEE;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rx(16'h200, 8, "aligned");
    t_rx(16'h301, 6, "unaligned");
    t_tx();
    t_w1c_irq();
    t_clamp();
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule